// File: doc/BRIEF.md
# Triggered Modulo Timer Counter

This block is a counter of configurable width with a power-of-two prescaler and a programmable modulo limit. It counts up and wraps to zero after the limit. With center alignment selected it counts up to the limit and back down to zero. The count advances from one of three sources: the prescaled internal clock, rising edges of an external clock pin, or rising edges of a trigger input. Both external signals are brought into the clock domain by a two-flop synchronizer before edges are detected.

A sticky overflow flag records every wrap or turnaround, together with a bit that shows whether it happened at the top or at the bottom. An interrupt request follows the flag when enabled. Three trigger-driven behaviours can be combined: holding the counter until a trigger edge arrives, stopping it at its first overflow, and reloading it to zero on a trigger edge. A write strobe clears the counter at any time.

Top module: `trig_modulo_timer`

## Requirements
- R1: While reset is asserted the count is 0, the overflow flag and the direction bit are 0, and the interrupt request is 0.
- R2: With clock mode 1 the count advances once every 2^presc clock cycles. In up-only mode a step taken when the count is at or above the modulo value gives 0 and an overflow; any other step adds one.
- R3: With center_sel set the count rises to the modulo value and falls back to 0. A step from the modulo value while rising gives modulo-1, and a step from 0 while falling gives 1.
- R4: With clock mode 0 the count and the flag hold their values whatever the other inputs do.
- R5: With clock mode 2 the count advances once per rising edge of ext_clk, with no prescaling. An edge takes effect on the third rising clock edge after the pin rises.
- R6: With clock mode 3 the count advances once per rising edge of the active trigger. trig_pol 0 makes trig_in active high and 1 makes it active low.
- R7: The overflow flag is set by each wrap or turnaround and is cleared by a cycle of ovf_clr. If both fall in the same cycle, the flag stays set.
- R8: ovf_dir takes 1 on an overflow at the top (a step from the modulo value upward) and 0 on an overflow at the bottom (a step from 0 while falling).
- R9: With start_on_trig set the count does not advance, after being enabled or after a stop, until a rising trigger edge is seen. That arming edge is not itself counted.
- R10: With stop_on_ovf set the counter stops on the step that overflows. With start_on_trig also set, a later trigger edge restarts it.
- R11: With reload_on_trig set and a nonzero clock mode, a rising trigger edge sets the count to 0. This takes priority over a step in the same cycle.
- R12: A cycle of cnt_wr sets the count to 0, sets the direction to rising and restarts the prescaler. It takes priority over every other action.
- R13: irq is 1 exactly when the overflow flag is 1 and ovf_ie is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_mode | input | 2 | Count source: 0 off, 1 internal, 2 external pin, 3 trigger |
| presc | input | PSC_W (3) | Prescale code; divides by 2^code |
| center_sel | input | 1 | 1 selects up-down counting |
| ovf_ie | input | 1 | Overflow interrupt enable |
| start_on_trig | input | 1 | Wait for a trigger edge before counting |
| stop_on_ovf | input | 1 | Stop counting after an overflow |
| reload_on_trig | input | 1 | Trigger edge clears the count |
| trig_pol | input | 1 | 0 active-high trigger, 1 active-low |
| modulo | input | CNT_W (16) | Limit value |
| cnt_wr | input | 1 | Counter write strobe; clears the count |
| ext_clk | input | 1 | External count clock pin |
| trig_in | input | 1 | Trigger input |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | CNT_W (16) | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_dir | output | 1 | 1 top overflow, 0 bottom overflow |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two collisions matter most. The first is an overflow that lands in the same cycle as an ovf_clr strobe. The bench times the strobe arithmetically into the wrapping cycle, expects the flag to survive, and then expects a clear with no overflow to drop it on the next cycle. The second is a trigger edge that is both a reload and an arming or restart event. The bench places it while the counter runs or stands stopped, and checks that the count reads 0 on the edge's cycle and the expected step count on the cycles after.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      CM_OFF      = 2'd0,
      CM_INTERNAL = 2'd1,
      CM_EXTCLK   = 2'd2,
      CM_TRIG     = 2'd3
   } clk_mode_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_sync_edge: STAGES must be at least 2");
   end

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   // R5 / R6: a detected edge lasts exactly one cycle
   p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int DIV_W = (1 << CODE_W) - 1;

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("tmr_prescaler: CODE_W must be 1..4");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    div_q <= '0;
      else if (!run) div_q <= '0;
      else           div_q <= div_q + 1'b1;
   end

   assign tick = run && ((div_q & mask) == mask);

   // R2: no tick while stopped
   p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (div_q == '0));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W     = 16,
   parameter bit CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             reload,
   input  logic             step,
   input  logic             center,
   input  logic [CNT_W-1:0] modulo,
   output logic [CNT_W-1:0] count,
   output logic             ovf_evt,
   output logic             ovf_top
);
   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_count_core: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             down_q, down_d;
   logic             updown;

   if (CENTER_EN) begin : g_center
      assign updown = center;
   end else begin : g_up_only
      assign updown = 1'b0;
   end

   always_comb begin
      cnt_d   = cnt_q;
      down_d  = down_q & updown;
      ovf_evt = 1'b0;
      ovf_top = 1'b0;
      if (clr || reload) begin
         cnt_d  = '0;
         down_d = 1'b0;
      end else if (step) begin
         if (!updown) begin
            down_d = 1'b0;
            if (cnt_q >= modulo) begin
               cnt_d   = '0;
               ovf_evt = 1'b1;
               ovf_top = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end else if (down_q) begin
            if (cnt_q == '0) begin
               cnt_d   = (modulo == '0) ? '0 : CNT_W'(1);
               down_d  = 1'b0;
               ovf_evt = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end else begin
            if (cnt_q >= modulo) begin
               ovf_evt = 1'b1;
               ovf_top = 1'b1;
               if (modulo == '0) begin
                  cnt_d = '0;
               end else begin
                  cnt_d  = modulo - 1'b1;
                  down_d = 1'b1;
               end
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
      end
   end

   assign count = cnt_q;

   // R12: a write strobe leaves the count at zero
   p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));
   // R4: without step, reload or clear the count holds
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !reload && !step) |=> $stable(cnt_q));
   // R2: an up-only step at or beyond the limit lands on zero
   p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !center && !clr && !reload && cnt_q >= modulo) |=> (cnt_q == '0));
   // R11: reload without clear leaves zero
   p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt_q == '0));
endmodule

// File: rtl/trig_modulo_timer.sv
module trig_modulo_timer #(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit CENTER_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       clk_mode,
   input  logic [PSC_W-1:0] presc,
   input  logic             center_sel,
   input  logic             ovf_ie,
   input  logic             start_on_trig,
   input  logic             stop_on_ovf,
   input  logic             reload_on_trig,
   input  logic             trig_pol,
   input  logic [CNT_W-1:0] modulo,
   input  logic             cnt_wr,
   input  logic             ext_clk,
   input  logic             trig_in,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf_flag,
   output logic             ovf_dir,
   output logic             irq
);
   import tmr_pkg::*;

   clk_mode_e mode;
   logic      enabled, run, psc_run, tick, src_edge, step, reload;
   logic      ext_rise, trig_rise;
   logic      halt_q, armed_q;
   logic      ovf_evt, ovf_top;

   assign mode    = clk_mode_e'(clk_mode);
   assign enabled = (mode != CM_OFF);

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_clk), .rise(ext_rise));

   tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk(clk), .rst_n(rst_n), .din(trig_in ^ trig_pol), .rise(trig_rise));

   // start / stop control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (!enabled) begin
         halt_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (ovf_evt && stop_on_ovf) begin
         halt_q  <= 1'b1;
         armed_q <= 1'b0;
      end else if (trig_rise) begin
         armed_q <= 1'b1;
         if (start_on_trig) halt_q <= 1'b0;
      end
   end

   assign run     = enabled && !halt_q && (!start_on_trig || armed_q);
   assign psc_run = run && (mode == CM_INTERNAL) && !cnt_wr;

   tmr_prescaler #(.CODE_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(psc_run), .code(presc), .tick(tick));

   always_comb begin
      case (mode)
         CM_INTERNAL: src_edge = tick;
         CM_EXTCLK:   src_edge = ext_rise;
         CM_TRIG:     src_edge = trig_rise;
         default:     src_edge = 1'b0;
      endcase
   end

   assign step   = run && src_edge;
   assign reload = enabled && reload_on_trig && trig_rise;

   tmr_count_core #(.CNT_W(CNT_W), .CENTER_EN(CENTER_EN)) u_core (
      .clk(clk), .rst_n(rst_n), .clr(cnt_wr), .reload(reload), .step(step),
      .center(center_sel), .modulo(modulo), .count(count),
      .ovf_evt(ovf_evt), .ovf_top(ovf_top));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         ovf_dir  <= 1'b0;
      end else if (ovf_evt) begin
         ovf_flag <= 1'b1;
         ovf_dir  <= ovf_top;
      end else if (ovf_clr) begin
         ovf_flag <= 1'b0;
      end
   end

   assign irq = ovf_flag & ovf_ie;

   // R7: an overflow always leaves the flag set, even against a clear
   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);
   // R7: a clear with no overflow drops the flag
   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !ovf_evt) |=> !ovf_flag);
   // R8: an up-only overflow is a top overflow
   p_dir_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !center_sel) |=> ovf_dir);
   // R10: a stopped counter takes no step
   p_halt_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !step);
   // R9: no step before arming when start-on-trigger is set
   p_wait_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_on_trig && !armed_q) |-> !step);
endmodule

// File: tb/sim_trig_modulo_timer.sv
module sim_trig_modulo_timer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  clk_mode;
   logic [2:0]  presc;
   logic        center_sel, ovf_ie, start_on_trig, stop_on_ovf, reload_on_trig, trig_pol;
   logic [15:0] modulo;
   logic        cnt_wr, ext_clk, trig_in, ovf_clr;
   logic [15:0] count;
   logic        ovf_flag, ovf_dir, irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   trig_modulo_timer u0 (
      .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .presc(presc),
      .center_sel(center_sel), .ovf_ie(ovf_ie), .start_on_trig(start_on_trig),
      .stop_on_ovf(stop_on_ovf), .reload_on_trig(reload_on_trig), .trig_pol(trig_pol),
      .modulo(modulo), .cnt_wr(cnt_wr), .ext_clk(ext_clk), .trig_in(trig_in),
      .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag), .ovf_dir(ovf_dir), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart();
      cnt_wr = 1'b1; ovf_clr = 1'b1;
      cyc(1);
      cnt_wr = 1'b0; ovf_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int hold;
      rst_n = 1'b0; clk_mode = 2'd0; presc = 3'd0; center_sel = 1'b0; ovf_ie = 1'b1;
      start_on_trig = 1'b0; stop_on_ovf = 1'b0; reload_on_trig = 1'b0; trig_pol = 1'b0;
      modulo = 16'd0; cnt_wr = 1'b0; ext_clk = 1'b0; trig_in = 1'b0; ovf_clr = 1'b0;
      cyc(3);
      chk("R1 count", int'(count), 0);
      chk("R1 flag", int'(ovf_flag), 0);
      chk("R1 dir", int'(ovf_dir), 0);
      chk("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      cyc(2);

      // R2 / R3 / R7 / R8 / R13 sweep over prescale, limit and counting style
      clk_mode = 2'd1;
      for (int code = 0; code < 4; code++) begin
         for (int mi = 0; mi < 4; mi++) begin
            for (int cs = 0; cs < 2; cs++) begin
               int m;
               m = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 2 : 5;
               if (cs == 1 && m == 0) continue;
               presc = 3'(code); modulo = 16'(m); center_sel = cs[0]; ovf_ie = code[0];
               restart();
               for (int n = 1; n <= 40; n++) begin
                  int s, e_cnt, e_flag, e_dir, p;
                  cyc(1);
                  s = n >> code;
                  e_flag = (s >= m + 1) ? 1 : 0;
                  if (cs == 0) begin
                     e_cnt = s % (m + 1);
                     e_dir = e_flag;
                     chk("R2 count", int'(count), e_cnt);
                  end else begin
                     p = s % (2 * m);
                     e_cnt = (p <= m) ? p : 2 * m - p;
                     e_dir = (e_flag == 1 && ((s - 1) % (2 * m)) >= m) ? 1 : 0;
                     chk("R3 count", int'(count), e_cnt);
                  end
                  chk("R7 flag", int'(ovf_flag), e_flag);
                  if (e_flag == 1) chk("R8 dir", int'(ovf_dir), e_dir);
                  chk("R13 irq", int'(irq), e_flag & code[0]);
               end
            end
         end
      end

      // R12: write strobe clears a running count
      presc = 3'd0; modulo = 16'd200; center_sel = 1'b0; ovf_ie = 1'b1;
      restart();
      cyc(17);
      chk("R12 before clear", int'(count), 17);
      cnt_wr = 1'b1; cyc(1); cnt_wr = 1'b0;
      chk("R12 cleared", int'(count), 0);

      // R4: mode 0 freezes the count
      cyc(9);
      hold = int'(count);
      clk_mode = 2'd0;
      cyc(12);
      chk("R4 hold", int'(count), hold);
      chk("R4 flag", int'(ovf_flag), 0);

      // R7: overflow and clear in the same cycle; R13 irq follows flag
      clk_mode = 2'd1; modulo = 16'd9;
      restart();
      cyc(9);
      ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
      chk("R7 set beats clear", int'(ovf_flag), 1);
      chk("R2 wrap", int'(count), 0);
      chk("R13 irq on", int'(irq), 1);
      ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
      chk("R7 clear", int'(ovf_flag), 0);
      chk("R13 irq off", int'(irq), 0);

      // R5: external clock pin, prescaler ignored
      clk_mode = 2'd2; presc = 3'd7; modulo = 16'd100;
      restart();
      cyc(5);
      chk("R5 idle", int'(count), 0);
      ext_clk = 1'b1; cyc(2);
      chk("R5 latency", int'(count), 0);
      cyc(1);
      chk("R5 first edge", int'(count), 1);
      ext_clk = 1'b0; cyc(3);
      for (int k = 0; k < 5; k++) begin
         ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3);
      end
      chk("R5 edges", int'(count), 6);

      // R6: trigger counting, active-low
      clk_mode = 2'd0; trig_pol = 1'b1; trig_in = 1'b1;
      cyc(5);
      clk_mode = 2'd3;
      restart();
      cyc(5);
      chk("R6 idle", int'(count), 0);
      for (int k = 0; k < 4; k++) begin
         trig_in = 1'b0; cyc(3); trig_in = 1'b1; cyc(3);
      end
      chk("R6 low edges", int'(count), 4);
      clk_mode = 2'd0; trig_pol = 1'b0; trig_in = 1'b0;
      cyc(5);
      clk_mode = 2'd3;
      restart();
      for (int k = 0; k < 3; k++) begin
         trig_in = 1'b1; cyc(3); trig_in = 1'b0; cyc(3);
      end
      chk("R6 high edges", int'(count), 3);

      // R9: start on trigger
      clk_mode = 2'd0; cyc(2);
      start_on_trig = 1'b1; clk_mode = 2'd1; presc = 3'd0; modulo = 16'd100;
      restart();
      cyc(20);
      chk("R9 waits", int'(count), 0);
      trig_in = 1'b1; cyc(3);
      chk("R9 arming edge", int'(count), 0);
      cyc(5);
      chk("R9 runs", int'(count), 5);
      trig_in = 1'b0;

      // R10: stop on overflow, restart by trigger
      stop_on_ovf = 1'b1; modulo = 16'd7;
      cyc(3);
      chk("R10 wrap", int'(count), 0);
      chk("R10 flag", int'(ovf_flag), 1);
      cyc(10);
      chk("R10 stopped", int'(count), 0);
      trig_in = 1'b1; cyc(3);
      chk("R10 restart edge", int'(count), 0);
      cyc(4);
      chk("R10 restarted", int'(count), 4);
      trig_in = 1'b0; stop_on_ovf = 1'b0; start_on_trig = 1'b0;
      cyc(3);

      // R11: reload on trigger
      reload_on_trig = 1'b1; modulo = 16'd200;
      restart();
      cyc(30);
      chk("R11 before", int'(count), 30);
      trig_in = 1'b1; cyc(2);
      chk("R11 pending", int'(count), 32);
      cyc(1);
      chk("R11 reloaded", int'(count), 0);
      cyc(1);
      chk("R11 resumes", int'(count), 1);
      trig_in = 1'b0; reload_on_trig = 1'b0;

      // R11: reload beats a trigger-mode step in the same cycle
      clk_mode = 2'd3; reload_on_trig = 1'b1;
      restart();
      cyc(3);
      trig_in = 1'b1; cyc(3);
      chk("R11 over step", int'(count), 0);
      trig_in = 1'b0; reload_on_trig = 1'b0;
      cyc(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule